// File: doc/BRIEF.md
# Packed Low-Precision Multiply-Accumulate Unit

This unit sits beside the integer pipeline of a small processor core and extends its datapath with four quantized neural-network operations. Each operation reads two 32-bit register operands, is selected by a 3-bit function code, and returns one 32-bit result. The result can be written back as an ordinary register-register instruction result.

The multiply hardware has two 8x4 lanes and two 4x4 lanes. In the byte mode the two wide lanes multiply signed 8-bit activations by signed 4-bit weights. In the nibble mode all four lanes multiply signed 4-bit activations by signed 4-bit weights, and the wide lanes take sign-extended nibbles. An adder tree sums the lane products into a 32-bit running accumulator that is kept between calls.

Two post-processing operations finish a layer. The first adds a 32-bit bias to the running sum, clamps negative values to zero and clears the accumulator for the next output. The second requantizes a value by an arithmetic right shift with round-half-up, then saturates it to a signed 4-bit or 8-bit range. Quantization is symmetric, so no zero point is ever subtracted.

Top module: `simd_mac_unit`

## Requirements
- R1: An accepted operation (opValid high with opSel 0 to 3 at a rising edge) sets resValid high and updates result in the following cycle. resValid stays high for that single cycle.
- R2: opSel=0 (byte MAC) adds sA0*wB0 + sA1*wB1 to the accumulator. sA0 = srcA[7:0] and sA1 = srcA[15:8] are signed bytes. wB0 = srcB[3:0] and wB1 = srcB[7:4] are signed nibbles. result is the new accumulator value.
- R3: opSel=1 (nibble MAC) adds the sum over k=0..3 of srcA[4k+3:4k]*srcB[4k+3:4k] to the accumulator, with every nibble signed. result is the new accumulator value.
- R4: The accumulator carries from one MAC call to the next, in either mode, and mixed modes add into the same total. Arithmetic is modulo 2^32.
- R5: opSel=2 (bias and ReLU) returns max(0, acc + srcA), with the sum read as signed 32-bit, and sets the accumulator to 0.
- R6: opSel=3 (rescale) shifts srcA right arithmetically by s = srcB[4:0]. When s>0 it first adds 2^(s-1) to srcA, so halves round toward plus infinity. It leaves the accumulator unchanged.
- R7: The rescale output saturates to [-8, 7] when srcB[5]=0 and to [-128, 127] when srcB[5]=1. The value is sign-extended to 32 bits.
- R8: opSel 4 to 7, or opValid low, gives no resValid, leaves result holding its last value and leaves the accumulator unchanged.
- R9: During and after reset, resValid and result are 0 and the accumulator is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Operation request this cycle |
| opSel | input | 3 | Function code selecting the operation |
| srcA | input | 32 | First register operand |
| srcB | input | 32 | Second register operand |
| resValid | output | 1 | Result strobe, one cycle after acceptance |
| result | output | 32 | Operation result |

## Verification
On every cycle the assertions check the following: the one-cycle strobe timing, the absence of a strobe for idle or unknown codes, and a non-negative output after bias-and-ReLU. They also check that the accumulator is cleared after a bias, that it holds on every non-MAC cycle, and that a rescale result stays inside the 8-bit bound. Lane packing, sign handling at the extremes (-128 by -8, -8 by -8), accumulation across mixed modes, rounding of exact halves and the choice between the 4-bit and 8-bit limits can only be shown by the bench scenarios. These are compared against the behavioural model.

// File: rtl/mac_pkg.sv
package mac_pkg;
  localparam int XLEN    = 32;
  localparam int ACT_W   = 8;
  localparam int WGT_W   = 4;
  localparam int NIB_W   = 4;
  localparam int WIDE_N  = 2;
  localparam int NARR_N  = 2;
  localparam int LANES   = WIDE_N + NARR_N;
  localparam int SHW     = $clog2(XLEN);
  localparam int SELW    = 3;

  localparam logic [SELW-1:0] SEL_MAC8  = 3'd0;
  localparam logic [SELW-1:0] SEL_MAC4  = 3'd1;
  localparam logic [SELW-1:0] SEL_BIAS  = 3'd2;
  localparam logic [SELW-1:0] SEL_SCALE = 3'd3;

  typedef struct packed {
    logic fire;
    logic macEn;
    logic quad;
    logic biasEn;
    logic scaleEn;
  } ctrlStrobes_t;
endpackage

// File: rtl/mac_ctrl.sv
module mac_ctrl
  import mac_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            opValid,
  input  logic [SELW-1:0] opSel,
  output ctrlStrobes_t    strb,
  output logic            resValid
);
  logic legal;

  always_comb begin
    strb  = '0;
    legal = 1'b1;
    unique case (opSel)
      SEL_MAC8:  strb.macEn   = 1'b1;
      SEL_MAC4:  begin strb.macEn = 1'b1; strb.quad = 1'b1; end
      SEL_BIAS:  strb.biasEn  = 1'b1;
      SEL_SCALE: strb.scaleEn = 1'b1;
      default:   legal = 1'b0;
    endcase
    if (!(opValid && legal)) strb = '0;
    strb.fire = opValid && legal;
  end

  always_ff @(posedge clk) begin
    if (!rstN) resValid <= 1'b0;
    else       resValid <= strb.fire;
  end

  // R1: accepted request produces a strobe one cycle later
  p_valid_next_r1: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opSel <= SEL_SCALE) |=> resValid);
  // R8: idle or unknown code yields no strobe
  p_no_strobe_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!opValid || opSel > SEL_SCALE) |=> !resValid);
endmodule

// File: rtl/mac_lane.sv
module mac_lane #(
  parameter int AW = 8,
  parameter int WW = 4
) (
  input  logic                 en,
  input  logic signed [AW-1:0] act,
  input  logic signed [WW-1:0] wgt,
  output logic signed [AW+WW-1:0] prod
);
  always_comb prod = en ? (AW+WW)'(act * wgt) : '0;
endmodule

// File: rtl/mac_datapath.sv
module mac_datapath
  import mac_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  ctrlStrobes_t    strb,
  input  logic [XLEN-1:0] srcA,
  input  logic [XLEN-1:0] srcB,
  output logic [XLEN-1:0] result
);
  localparam int WPW = ACT_W + WGT_W;
  localparam int NPW = NIB_W + WGT_W;

  logic signed [XLEN-1:0] laneExt [LANES];
  logic [XLEN-1:0] laneSum, accQ, macNext, biasSum, reluOut, scaleOut, resNext;

  // wide lanes: bytes in byte mode, sign-extended nibbles in nibble mode
  for (genvar k = 0; k < WIDE_N; k++) begin : g_wide
    logic signed [ACT_W-1:0] actIn;
    logic signed [WPW-1:0]   prodW;
    always_comb actIn = strb.quad
      ? ACT_W'($signed(srcA[k*NIB_W +: NIB_W]))
      : srcA[k*ACT_W +: ACT_W];
    mac_lane #(.AW(ACT_W), .WW(WGT_W)) i_lane (
      .en(strb.macEn), .act(actIn), .wgt(srcB[k*WGT_W +: WGT_W]), .prod(prodW));
    always_comb laneExt[k] = XLEN'(prodW);
  end

  // narrow lanes: active only in nibble mode
  for (genvar k = WIDE_N; k < LANES; k++) begin : g_narrow
    logic signed [NPW-1:0] prodN;
    mac_lane #(.AW(NIB_W), .WW(WGT_W)) i_lane (
      .en(strb.macEn && strb.quad), .act(srcA[k*NIB_W +: NIB_W]),
      .wgt(srcB[k*WGT_W +: WGT_W]), .prod(prodN));
    always_comb laneExt[k] = XLEN'(prodN);
  end

  // adder tree over lane products
  logic [XLEN-1:0] pairSum [LANES/2];
  for (genvar p = 0; p < LANES/2; p++) begin : g_pair
    always_comb pairSum[p] = laneExt[2*p] + laneExt[2*p+1];
  end
  always_comb begin
    laneSum = '0;
    for (int p = 0; p < LANES/2; p++) laneSum = laneSum + pairSum[p];
  end

  always_comb macNext = accQ + laneSum;

  // bias and ReLU
  always_comb begin
    biasSum = accQ + srcA;
    reluOut = biasSum[XLEN-1] ? '0 : biasSum;
  end

  // rounding shift and saturation
  logic [SHW-1:0]      shAmt;
  logic signed [XLEN:0] roundC, sumR, shifted, hiLim, loLim;
  always_comb begin
    shAmt   = srcB[SHW-1:0];
    roundC  = (shAmt == '0) ? '0 : ((XLEN+1)'(1) <<< (shAmt - 1'b1));
    sumR    = $signed({srcA[XLEN-1], srcA}) + roundC;
    shifted = sumR >>> shAmt;
    hiLim   = srcB[SHW] ? (XLEN+1)'(127) : (XLEN+1)'(7);
    loLim   = srcB[SHW] ? -(XLEN+1)'(128) : -(XLEN+1)'(8);
    if (shifted > hiLim)      scaleOut = hiLim[XLEN-1:0];
    else if (shifted < loLim) scaleOut = loLim[XLEN-1:0];
    else                      scaleOut = shifted[XLEN-1:0];
  end

  always_comb begin
    resNext = result;
    if (strb.macEn)   resNext = macNext;
    if (strb.biasEn)  resNext = reluOut;
    if (strb.scaleEn) resNext = scaleOut;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accQ   <= '0;
      result <= '0;
    end else begin
      if (strb.macEn)       accQ <= macNext;
      else if (strb.biasEn) accQ <= '0;
      if (strb.fire)        result <= resNext;
    end
  end

  // R5: ReLU output never negative
  p_relu_nonneg_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.biasEn |=> !result[XLEN-1]);
  // R5: bias starts a fresh accumulation
  p_acc_cleared_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.biasEn |=> (accQ == '0));
  // R8 / R6: non-MAC, non-bias cycles leave the accumulator alone
  p_acc_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.macEn && !strb.biasEn) |=> $stable(accQ));
  // R7: rescale never leaves the widest saturation range
  p_scale_sat_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.scaleEn |=> ($signed(result) <= 127 && $signed(result) >= -128));
endmodule

// File: rtl/simd_mac_unit.sv
module simd_mac_unit
  import mac_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            opValid,
  input  logic [2:0]      opSel,
  input  logic [31:0]     srcA,
  input  logic [31:0]     srcB,
  output logic            resValid,
  output logic [31:0]     result
);
  ctrlStrobes_t strb;

  mac_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opSel(opSel),
    .strb(strb), .resValid(resValid));

  mac_datapath i_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .srcA(srcA), .srcB(srcB), .result(result));

  // R9: outputs quiet in the cycle after reset
  p_reset_quiet_r9: assert property (@(posedge clk)
    !rstN |=> (!resValid && result == '0));
endmodule

// File: tb/test_simd_mac_unit.sv
module test_simd_mac_unit;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 0, rstN = 0, opValid = 0;
  logic [2:0] opSel = 0;
  logic [31:0] srcA = 0, srcB = 0;
  logic resValid;
  logic [31:0] result;

  int errors = 0, checks = 0;
  bit done = 0;

  logic        expValid = 0;
  logic [31:0] expResult = 0;
  longint      modelAcc = 0;
  string       expTag = "R9";

  simd_mac_unit i_simd_mac_unit (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic longint sx(input longint v, input int w);
    longint m = longint'(1) << (w-1);
    return ((v & ((m<<1)-1)) ^ m) - m;
  endfunction

  task automatic compare();
    checks++;
    if (resValid !== expValid || result !== expResult) begin
      errors++;
      $display("FAIL %s: valid=%0b result=%0d expected valid=%0b result=%0d",
               expTag, resValid, $signed(result), expValid, $signed(expResult));
    end
  endtask

  // check the previous op's outcome, then drive and model the next one
  task automatic step(input bit v, input logic [2:0] s,
                      input logic [31:0] a, input logic [31:0] b, input string tag);
    longint sum, val;
    int sh;
    @(negedge clk);
    compare();
    opValid = v; opSel = s; srcA = a; srcB = b;
    expTag = tag;
    expValid = v && s <= 3;
    if (v) begin
      case (s)
        3'd0: begin
          sum = 0;
          for (int k = 0; k < 2; k++)
            sum += sx(a >> (8*k), 8) * sx(b >> (4*k), 4);
          modelAcc = sx(modelAcc + sum, 32);
          expResult = 32'(modelAcc);
        end
        3'd1: begin
          sum = 0;
          for (int k = 0; k < 4; k++)
            sum += sx(a >> (4*k), 4) * sx(b >> (4*k), 4);
          modelAcc = sx(modelAcc + sum, 32);
          expResult = 32'(modelAcc);
        end
        3'd2: begin
          val = sx(modelAcc + sx(a, 32), 32);
          expResult = (val < 0) ? 0 : 32'(val);
          modelAcc = 0;
        end
        3'd3: begin
          sh = b[4:0];
          val = sx(a, 32);
          if (sh > 0) val += longint'(1) << (sh-1);
          val = val >>> sh;
          if (b[5]) val = (val > 127) ? 127 : (val < -128) ? -128 : val;
          else      val = (val > 7) ? 7 : (val < -8) ? -8 : val;
          expResult = 32'(val);
        end
        default: ;
      endcase
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R9: reset state
    repeat (3) @(posedge clk);
    @(negedge clk); compare();
    rstN = 1;
    step(0, 0, 0, 0, "R9");
    // R2: byte lanes, extremes: -128*-8 + 127*7
    step(1, 0, 32'h0000_7F80, 32'h0000_0078, "R2");
    step(1, 0, 32'h0000_02FD, 32'h0000_0035, "R2/R4");
    // R3: nibble lanes, -8*-8 and mixed signs; upper bytes ignored in byte mode
    step(1, 1, 32'h0000_8F37, 32'h0000_8F2F, "R3/R4");
    step(1, 0, 32'hFFFF_0101, 32'hFFFF_FF11, "R2/R4");
    // R8: idle and unknown codes
    step(0, 0, 32'h0000_7F7F, 32'h0000_0077, "R8");
    step(1, 5, 32'h0000_7F7F, 32'h0000_0077, "R8");
    step(1, 7, 32'h1234_5678, 32'h0000_0077, "R8");
    // R5: positive bias, then clear
    step(1, 2, 32'd100, 0, "R5");
    step(1, 1, 32'h0000_1111, 32'h0000_1111, "R5/R3");
    // R5: negative sum clamps to zero
    step(1, 2, -32'd50, 0, "R5");
    step(1, 0, 32'h0000_0001, 32'h0000_0001, "R5/R4");
    // R6: rounding, shift 0, exact halves
    step(1, 3, -32'd3, 32'h21, "R6");
    step(1, 3, 32'd5, 32'h21, "R6");
    step(1, 3, 32'd100, 32'h20, "R6/R7");
    step(1, 3, 32'd200, 32'h22, "R6");
    step(1, 3, -32'd6, 32'h22, "R6");
    // R7: saturation by width
    step(1, 3, 32'd1000, 32'h02, "R7");
    step(1, 3, -32'd1000, 32'h02, "R7");
    step(1, 3, 32'h7FFF_FFFF, 32'h38, "R7");
    step(1, 3, 32'h8000_0000, 32'h1F, "R6/R7");
    // R4: accumulator untouched by rescale
    step(1, 0, 32'h0000_0002, 32'h0000_0003, "R4");
    step(1, 2, 0, 0, "R5/R4");
    step(0, 0, 0, 0, "R1");
    step(0, 0, 0, 0, "R1");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule